// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a synthesizable behavioural model of a clocked static memory. It works in register-to-register mode. Each word is 18 bits wide and split into two 9-bit byte lanes. The depth is a parameter and defaults to 1024 words. Commands are sampled on the rising clock edge:

- chip select
- write enable
- the two byte write enables
- the address

A read returns its word one clock later from an output register. A write takes its data from the bus one clock after its address ("late write").

The written word is parked in a one-entry pending buffer together with its address and lane enables. It is committed to the array only when the next write delivers its own data. A read whose address hits the buffered entry gets the buffered lanes merged over the array contents, so reads always see the latest write.

The bidirectional data bus appears as separate `data_i`, `data_o` and `data_oe_o` signals. An asynchronous output enable and a sleep input can force the bus to high impedance at any moment.

Top module: `lw_sram`

## Requirements
- R1: A write is sampled at edge e when `sleep_i`=0, `sel_ni`=0 and `we_ni`=0. The word on `data_i` at edge e+1 is stored at the sampled address. Lane 0 is bits 8:0 and is controlled by `bwe_ni[0]`. Lane 1 is bits 17:9 and is controlled by `bwe_ni[1]`. A lane is written only when its enable is 0.
- R2: A read is sampled at edge e when `sleep_i`=0, `sel_ni`=0, `we_ni`=1 and `oe_ni`=0. After edge e+1, `data_oe_o`=1 and `data_o` holds the newest content of that address. This holds unless the output is suppressed by R7, R8 or R9.
- R3: A read issued while the addressed word is still held in the pending write buffer returns the buffered lanes merged with the array lanes. This includes a read issued in the data cycle of that write.
- R4: A write with both byte enables at 1 changes no lane.
- R5: With `sel_ni`=1 at edge e, `data_oe_o` is 0 in the cycle after edge e+1.
- R6: A dummy read (select 0, `we_ni`=1, `oe_ni`=1 at edge e) does not access the array. `data_oe_o` stays 0 in the cycle after edge e+1.
- R7: In the data cycle of a write (between edge e and edge e+1), `data_oe_o` is 0. This holds even when the previous cycle was a read, whose output is then dropped.
- R8: While `sleep_i`=1, `data_oe_o` is 0. Any command sampled with `sleep_i`=1 is ignored. A write already sampled still completes its data phase.
- R9: `oe_ni`=1 drives `data_oe_o` to 0 combinationally, with no clock edge needed.
- R10: After reset, `data_oe_o` is 0 until the first read has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Chip select, active low, sampled |
| we_ni | input | 1 | Write enable, active low, sampled |
| bwe_ni | input | 2 | Byte lane write enables, active low, sampled |
| addr_i | input | AW (10) | Word address, sampled |
| oe_ni | input | 1 | Output enable, active low; sampled for dummy-read decode and also applied asynchronously |
| sleep_i | input | 1 | Sleep, active high |
| data_i | input | 18 | Write data, taken one edge after the write command |
| data_o | output | 18 | Read data from the output register |
| data_oe_o | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
The hardest case to reach from the ports is a read that hits a word still waiting in the pending buffer with only some of its lanes enabled. That read must return a mix of buffered and array lanes. It also cannot complete if the next cycle is a write, which would take the bus away from it.

The directed part of the stimulus sets this up with write/read pairs to the same address. Some pairs use a single lane and some use no lane. The random part draws addresses from a pool of seventeen, so back-to-back hits on the buffered address happen often. Sleep, dummy-read and output-enable cycles are sprinkled into the random stream, so the suppression rules overlap with the forwarding cases.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
  import lw_sram_pkg::*;
#(
  parameter int AW    = 10,
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_ni,
  input  logic             we_ni,
  input  logic [LANES-1:0] bwe_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             oe_ni,
  input  logic             sleep_i,
  output op_e              op_o,
  output logic [AW-1:0]    addr_o,
  output logic [LANES-1:0] bwe_o
);
  op_e              op_d, op_q;
  logic [AW-1:0]    addr_q;
  logic [LANES-1:0] bwe_q;

  always_comb begin
    if (sleep_i || sel_ni) op_d = OP_IDLE;
    else if (!we_ni)       op_d = OP_WRITE;
    else if (oe_ni)        op_d = OP_IDLE;   // dummy read: no array access
    else                   op_d = OP_READ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      bwe_q  <= '1;
    end else begin
      op_q   <= op_d;
      addr_q <= addr_i;
      bwe_q  <= bwe_ni;
    end
  end

  assign op_o   = op_q;
  assign addr_o = addr_q;
  assign bwe_o  = bwe_q;
endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf #(
  parameter int AW     = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] bwe_i,
  input  logic [DW-1:0]    data_i,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic [DW-1:0]    arr_rd_i,
  output logic             commit_o,
  output logic [AW-1:0]    commit_addr_o,
  output logic [LANES-1:0] commit_bwe_o,
  output logic [DW-1:0]    commit_data_o,
  output logic [DW-1:0]    merged_o
);
  logic             vld_q;
  logic [AW-1:0]    addr_q;
  logic [LANES-1:0] bwe_q;
  logic [DW-1:0]    data_q;
  logic             hit;

  // older entry drains to the array when a newer write captures its data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      bwe_q  <= '1;
      data_q <= '0;
    end else if (cap_i) begin
      vld_q  <= 1'b1;
      addr_q <= addr_i;
      bwe_q  <= bwe_i;
      data_q <= data_i;
    end
  end

  assign commit_o      = cap_i && vld_q;
  assign commit_addr_o = addr_q;
  assign commit_bwe_o  = bwe_q;
  assign commit_data_o = data_q;

  assign hit = vld_q && (addr_q == rd_addr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign merged_o[l*LANE_W +: LANE_W] = (hit && !bwe_q[l]) ?
        data_q[l*LANE_W +: LANE_W] : arr_rd_i[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int DEPTH  = 1024,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [LANES-1:0] wbe_ni,
  input  logic [DW-1:0]    wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && !wbe_ni[l]) mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_ni,
  input  logic             we_ni,
  input  logic [LANES-1:0] bwe_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             oe_ni,
  input  logic             sleep_i,
  input  logic [DW-1:0]    data_i,
  output logic [DW-1:0]    data_o,
  output logic             data_oe_o
);
  op_e              op;
  logic [AW-1:0]    cmd_addr;
  logic [LANES-1:0] cmd_bwe;
  logic             commit;
  logic [AW-1:0]    commit_addr;
  logic [LANES-1:0] commit_bwe;
  logic [DW-1:0]    commit_data;
  logic [DW-1:0]    arr_rd;
  logic [DW-1:0]    merged;
  logic [DW-1:0]    out_q;
  logic             out_vld_q;
  logic             wr_phase;

  lw_sram_ctrl #(.AW(AW), .LANES(LANES)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_ni  (sel_ni),
    .we_ni   (we_ni),
    .bwe_ni  (bwe_ni),
    .addr_i  (addr_i),
    .oe_ni   (oe_ni),
    .sleep_i (sleep_i),
    .op_o    (op),
    .addr_o  (cmd_addr),
    .bwe_o   (cmd_bwe)
  );

  assign wr_phase = (op == OP_WRITE);

  lw_sram_wbuf #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) i_wbuf (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cap_i         (wr_phase),
    .addr_i        (cmd_addr),
    .bwe_i         (cmd_bwe),
    .data_i        (data_i),
    .rd_addr_i     (cmd_addr),
    .arr_rd_i      (arr_rd),
    .commit_o      (commit),
    .commit_addr_o (commit_addr),
    .commit_bwe_o  (commit_bwe),
    .commit_data_o (commit_data),
    .merged_o      (merged)
  );

  lw_sram_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) i_array (
    .clk_i   (clk_i),
    .we_i    (commit),
    .waddr_i (commit_addr),
    .wbe_ni  (commit_bwe),
    .wdata_i (commit_data),
    .raddr_i (cmd_addr),
    .rdata_o (arr_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q     <= '0;
      out_vld_q <= 1'b0;
    end else begin
      out_vld_q <= (op == OP_READ);
      if (op == OP_READ) out_q <= merged;
    end
  end

  assign data_o    = out_q;
  // bus belongs to write data in the data cycle; oe and sleep act asynchronously
  assign data_oe_o = out_vld_q && !wr_phase && !oe_ni && !sleep_i;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sel_ni,
  input logic we_ni,
  input logic oe_ni,
  input logic sleep_i,
  input logic data_oe_o
);
  logic is_rd, is_wr, is_dummy;
  assign is_rd    = !sleep_i && !sel_ni && we_ni && !oe_ni;
  assign is_wr    = !sleep_i && !sel_ni && !we_ni;
  assign is_dummy = !sleep_i && !sel_ni && we_ni && oe_ni;

  p_read_drive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rd ##1 !is_wr |-> ##1 (data_oe_o || oe_ni || sleep_i));

  p_desel_hiz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && sel_ni) |-> ##2 !data_oe_o);

  p_dummy_hiz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_dummy |-> ##2 !data_oe_o);

  p_wdata_hiz_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wr |=> !data_oe_o);

  p_sleep_hiz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !data_oe_o);

  p_sleep_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> ##2 !data_oe_o);

  p_oe_hiz_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !data_oe_o);

  p_reset_hiz_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !data_oe_o);
endmodule

bind lw_sram lw_sram_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_ni    (sel_ni),
  .we_ni     (we_ni),
  .oe_ni     (oe_ni),
  .sleep_i   (sleep_i),
  .data_oe_o (data_oe_o)
);

// File: tb/test_lw_sram.sv
module test_lw_sram;
  localparam int DEPTH = 1024;
  localparam int AW    = 10;
  localparam int DW    = 18;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sel_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b0, sleep_i = 1'b0;
  logic [1:0]    bwe_ni = 2'b11;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic          data_oe_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [DW-1:0] mdl [DEPTH];
  bit            prev_rd = 0, prev_wr = 0;
  logic [AW-1:0] prev_addr = '0;
  logic [1:0]    prev_be = 2'b11;
  logic [DW-1:0] prev_wd = '0;
  bit            exp_vld = 0;
  logic [DW-1:0] exp_val = '0;

  always #2 clk_i = ~clk_i;

  lw_sram i_lw_sram (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_ni(sel_ni), .we_ni(we_ni),
    .bwe_ni(bwe_ni), .addr_i(addr_i), .oe_ni(oe_ni), .sleep_i(sleep_i),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                              input logic [1:0] be);
    logic [DW-1:0] r;
    r = old;
    if (!be[0]) r[8:0]  = nw[8:0];
    if (!be[1]) r[17:9] = nw[17:9];
    return r;
  endfunction

  // called at a negative edge; leaves at the next negative edge
  task automatic step(input bit s_n, input bit w_n, input logic [1:0] be, input int a,
                      input logic [DW-1:0] wd, input bit o_n, input bit slp, input string tag);
    bit cur_rd, cur_wr, exp_oe;
    sel_ni = s_n; we_ni = w_n; bwe_ni = be; addr_i = AW'(a); oe_ni = o_n; sleep_i = slp;
    data_i = prev_wr ? prev_wd : DW'($urandom);
    @(posedge clk_i);
    if (prev_wr) mdl[prev_addr] = lane_merge(mdl[prev_addr], prev_wd, prev_be);
    exp_vld = prev_rd;
    if (prev_rd) exp_val = mdl[prev_addr];
    cur_rd = !slp && !s_n && w_n && !o_n;
    cur_wr = !slp && !s_n && !w_n;
    prev_rd = cur_rd; prev_wr = cur_wr; prev_addr = AW'(a); prev_be = be; prev_wd = wd;
    #1;
    exp_oe = exp_vld && !cur_wr && !o_n && !slp;
    if (slp)                 chk("R8 oe", DW'(data_oe_o), DW'(exp_oe));
    else if (o_n)            chk("R9 oe", DW'(data_oe_o), DW'(exp_oe));
    else if (cur_wr)         chk("R7 oe", DW'(data_oe_o), DW'(exp_oe));
    else                     chk("R2 oe", DW'(data_oe_o), DW'(exp_oe));
    if (exp_oe) chk(tag, data_o, exp_val);
    @(negedge clk_i);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d, input logic [1:0] be);
    step(1'b0, 1'b0, be, a, d, 1'b0, 1'b0, "R1");
  endtask
  task automatic rd(input int a, input string tag);
    step(1'b0, 1'b1, 2'b11, a, '0, 1'b0, 1'b0, tag);
  endtask
  task automatic idle(input string tag);
    step(1'b1, 1'b1, 2'b11, 0, '0, 1'b0, 1'b0, tag);
  endtask

  function automatic int pick_addr();
    int v;
    v = int'($urandom % 17);
    return (v == 16) ? DEPTH - 1 : v;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk("R10 oe in reset", DW'(data_oe_o), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 oe after reset", DW'(data_oe_o), '0);
    idle("R10");
    chk("R10 oe idle", DW'(data_oe_o), '0);

    // fill the address pool (R1)
    for (int i = 0; i < 17; i++) wr((i == 16) ? DEPTH - 1 : i, DW'($urandom), 2'b00);
    idle("R1");
    for (int i = 0; i < 17; i++) rd((i == 16) ? DEPTH - 1 : i, "R1 readback");
    idle("R1");

    // R3: read in the write's data cycle and while still buffered
    wr(3, 18'h2a5c3, 2'b00); rd(3, "R3 full fwd"); idle("R3");
    wr(4, 18'h15a5a, 2'b10); rd(4, "R3 lane0 fwd"); idle("R3");
    wr(4, 18'h3ffff, 2'b01); idle("R3"); rd(4, "R3 lane1 fwd"); idle("R3");
    // R4: no lane enabled
    wr(5, 18'h3ffff, 2'b11); rd(5, "R4 no lane"); idle("R4");
    wr(6, 18'h00001, 2'b00); rd(5, "R4 after drain"); idle("R4");
    // R5: read then deselect
    rd(1, "R5"); idle("R5"); idle("R5");
    chk("R5 desel hiz", DW'(data_oe_o), '0);
    // R6: dummy read
    step(1'b0, 1'b1, 2'b11, 2, '0, 1'b1, 1'b0, "R6");
    idle("R6");
    chk("R6 dummy hiz", DW'(data_oe_o), '0);
    // R7: read followed by write loses bus
    rd(7, "R7"); wr(8, 18'h0beef, 2'b00); idle("R7"); rd(8, "R7 write landed"); idle("R7");
    // R8: sleep blocks write and read
    step(1'b0, 1'b0, 2'b00, 9, 18'h11111, 1'b0, 1'b1, "R8");
    rd(9, "R8 write blocked"); idle("R8");
    step(1'b0, 1'b1, 2'b11, 9, '0, 1'b0, 1'b1, "R8");
    idle("R8");
    chk("R8 read blocked", DW'(data_oe_o), '0);
    // R9: asynchronous output enable
    rd(10, "R9"); idle("R9");
    oe_ni = 1'b1; #0.5;
    chk("R9 async hiz", DW'(data_oe_o), '0);
    oe_ni = 1'b0; #0.5;
    chk("R9 async drive", DW'(data_oe_o), 1'b1);
    idle("R9");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r, a;
      bit o_n, slp;
      r = int'($urandom % 10);
      a = pick_addr();
      o_n = ($urandom % 8) == 0;
      slp = ($urandom % 16) == 0;
      if (r < 4)      step(1'b0, 1'b0, 2'($urandom), a, DW'($urandom), o_n, slp, "R1 rnd");
      else if (r < 8) step(1'b0, 1'b1, 2'b11, a, '0, o_n, slp, "R3 rnd");
      else if (r == 8) step(1'b1, 1'($urandom), 2'($urandom), a, '0, o_n, slp, "R5 rnd");
      else            step(1'($urandom), 1'($urandom), 2'($urandom), a, DW'($urandom), o_n, slp, "R2 rnd");
    end
    idle("R2");
    for (int i = 0; i < 17; i++) rd((i == 16) ? DEPTH - 1 : i, "R2 final");
    idle("R2");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule